// File: doc/BRIEF.md
# Byte-Pair 8b/10b Transmit Encoder

This block is the last coding stage of a serial transmit lane. Once per slow fabric clock it captures a 16-bit word, two control identifiers, two force-disparity bits and two disparity-value bits. It then emits one 10-bit code group per fast clock, which runs at exactly twice the slow rate. The low byte is sent first. Keeping the fabric-side rate at half the symbol rate keeps the fabric logic within its frequency limit: a 3.125 Gbps line needs a 156.25 MHz fabric clock here rather than 312.5 MHz.

Each byte is coded by a 6-bit stage on bits [4:0] (x) and then a 4-bit stage on bits [7:5] (y). Running disparity is carried from one stage to the next and from one symbol to the next. A per-byte override can load the running disparity before the byte is coded. A control identifier raised on a byte that is not a legal special character raises a flag, and that byte is coded as data.

Top module: `byte_pair_8b10b_tx`

## Requirements
- R1: A word captured on a rising slow edge yields its low byte's code group on the next rising fast edge and its high byte's code group on the fast edge after that, which coincides with the next slow edge. Reset must be released so that the first fast edge after release is also a slow edge.
- R2: With the control identifier low, a byte codes to Dx.y, where x is bits [4:0] and y is bits [7:5]. code_out[0..5] carry bits a,b,c,d,e,i and code_out[6..9] carry f,g,h,j. Bit 0 goes to the line first. Examples: 0x83 gives D3.4, 0x78 gives D24.3 and 0x3C gives D28.1.
- R3: With the identifier high, the legal specials code to Kx.y. They are 0x1C+32·y (K28.0 to K28.7), 0xF7, 0xFB, 0xFD and 0xFE. 0xBC gives K28.5, which is 001111 1010 from negative disparity.
- R4: Every code group has 4, 5 or 6 ones. Running disparity flips after each unbalanced sub-block, so it always stays at ±1.
- R5: For y=7, the alternate 4-bit code is used for x in {17,18,20} when disparity is negative and for x in {11,13,14} when it is positive. Otherwise the primary code is used.
- R6: When disp_force[n] is high, the running disparity is loaded before byte n is coded. disp_pos[n]=1 loads positive and 0 loads negative. Bit 0 belongs to the low byte.
- R7: ctl_invalid is high together with the code group of a byte whose identifier is high but is not a legal special, and that byte is coded as data. ctl_invalid is low otherwise.
- R8: Reset clears code_out and ctl_invalid to zero, clears the captured word and sets running disparity negative.
- R9: D7 and the y=3 sub-block invert when disparity is positive even though they are balanced. For K28 entered at positive disparity, the entire group is the bitwise complement of its negative-disparity form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Symbol clock, twice the slow rate, edges aligned |
| clk_slow | input | 1 | Fabric word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_word | input | 16 | Word to send; [7:0] goes out first |
| tx_k | input | 2 | Control identifier per byte |
| disp_force | input | 2 | Per-byte running-disparity override enable |
| disp_pos | input | 2 | Per-byte override value, 1 = positive |
| code_out | output | 10 | Code group, bit 0 = a |
| ctl_invalid | output | 1 | Identifier raised on an illegal special |

## Verification
A disparity override and the invalid-control flag can act on the same byte in the same fast cycle. The bench provokes this by forcing positive disparity on a byte of 0xF1 with the identifier high. It then expects the flag together with the positive-disparity D17.7, which uses the primary 4-bit code rather than the alternate. A second overlap forces positive disparity onto K28.5, where the override and the K28 complement rule decide the group together. Both cases are judged against literal code tables, and the running disparity is tracked from the observed groups.

// File: rtl/byte_pair_8b10b_tx.sv
module byte_pair_8b10b_tx (
  input  logic        clk_fast,
  input  logic        clk_slow,
  input  logic        rst_n,
  input  logic [15:0] tx_word,
  input  logic [1:0]  tx_k,
  input  logic [1:0]  disp_force,
  input  logic [1:0]  disp_pos,
  output logic [9:0]  code_out,
  output logic        ctl_invalid
);

  function automatic logic [5:0] six_neg(input logic [4:0] x);
    case (x)
      5'd0:  six_neg = 6'b100111;  5'd1:  six_neg = 6'b011101;
      5'd2:  six_neg = 6'b101101;  5'd3:  six_neg = 6'b110001;
      5'd4:  six_neg = 6'b110101;  5'd5:  six_neg = 6'b101001;
      5'd6:  six_neg = 6'b011001;  5'd7:  six_neg = 6'b111000;
      5'd8:  six_neg = 6'b111001;  5'd9:  six_neg = 6'b100101;
      5'd10: six_neg = 6'b010101;  5'd11: six_neg = 6'b110100;
      5'd12: six_neg = 6'b001101;  5'd13: six_neg = 6'b101100;
      5'd14: six_neg = 6'b011100;  5'd15: six_neg = 6'b010111;
      5'd16: six_neg = 6'b011011;  5'd17: six_neg = 6'b100011;
      5'd18: six_neg = 6'b010011;  5'd19: six_neg = 6'b110010;
      5'd20: six_neg = 6'b001011;  5'd21: six_neg = 6'b101010;
      5'd22: six_neg = 6'b011010;  5'd23: six_neg = 6'b111010;
      5'd24: six_neg = 6'b110011;  5'd25: six_neg = 6'b100110;
      5'd26: six_neg = 6'b010110;  5'd27: six_neg = 6'b110110;
      5'd28: six_neg = 6'b001110;  5'd29: six_neg = 6'b101110;
      5'd30: six_neg = 6'b011110;  default: six_neg = 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] four_neg(input logic [2:0] y, input logic alt);
    case (y)
      3'd0:    four_neg = 4'b1011;
      3'd1:    four_neg = 4'b1001;
      3'd2:    four_neg = 4'b0101;
      3'd3:    four_neg = 4'b1100;
      3'd4:    four_neg = 4'b1101;
      3'd5:    four_neg = 4'b1010;
      3'd6:    four_neg = 4'b0110;
      default: four_neg = alt ? 4'b0111 : 4'b1110;
    endcase
  endfunction

  logic [15:0] word_q;
  logic [1:0]  k_q, frc_q, pos_q;

  always_ff @(posedge clk_slow or negedge rst_n)
    if (!rst_n) begin
      word_q <= '0; k_q <= '0; frc_q <= '0; pos_q <= '0;
    end else begin
      word_q <= tx_word; k_q <= tx_k; frc_q <= disp_force; pos_q <= disp_pos;
    end

  logic phase, rd_q;
  logic [7:0] sym;
  logic sym_k, rd_in;
  assign sym   = phase ? word_q[7:0] : word_q[15:8];
  assign sym_k = phase ? k_q[0] : k_q[1];
  assign rd_in = (phase ? frc_q[0] : frc_q[1]) ? (phase ? pos_q[0] : pos_q[1]) : rd_q;

  logic [4:0] x;
  logic [2:0] y;
  logic legal, k_ok, k28, unbal6, unbal4, rd_mid, rd_nx, alt;
  logic [5:0] s6, c6;
  logic [3:0] s4, c4p, c4;
  logic [9:0] lit, code_nx;

  assign x      = sym[4:0];
  assign y      = sym[7:5];
  assign legal  = (x == 5'd28) ||
                  (y == 3'd7 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
  assign k_ok   = sym_k && legal;
  assign k28    = k_ok && x == 5'd28;
  assign s6     = k28 ? 6'b001111 : six_neg(x);
  assign unbal6 = $countones(s6) != 3;
  assign c6     = (rd_in && (unbal6 || (x == 5'd7 && !k28))) ? ~s6 : s6;
  assign rd_mid = unbal6 ? ~rd_in : rd_in;
  assign alt    = (y == 3'd7) &&
                  (k_ok || (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                   (rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
  assign s4     = four_neg(y, alt);
  assign unbal4 = $countones(s4) != 2;
  assign c4p    = (unbal4 || y == 3'd3) ? ~s4 : s4;
  assign c4     = rd_mid ? c4p : (k28 ? ~c4p : s4);
  assign rd_nx  = unbal4 ? ~rd_mid : rd_mid;
  assign lit    = {c6, c4};

  always_comb
    for (int i = 0; i < 10; i++) code_nx[i] = lit[9-i];

  always_ff @(posedge clk_fast or negedge rst_n)
    if (!rst_n) begin
      phase <= 1'b0; rd_q <= 1'b0; code_out <= '0; ctl_invalid <= 1'b0;
    end else begin
      phase       <= ~phase;
      rd_q        <= rd_nx;
      code_out    <= code_nx;
      ctl_invalid <= sym_k && !legal;
    end

  // R4: group weight and disparity state agree
  a_r4_weight: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $past(rst_n) |-> ($countones(code_out) >= 4 && $countones(code_out) <= 6));
  a_r4_rd_heavy: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ($countones(code_out) == 6) |-> rd_q);
  a_r4_rd_light: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ($past(rst_n) && $countones(code_out) == 4) |-> !rd_q);
  // R1: byte select alternates and is on the low byte just after each slow edge
  a_r1_toggle: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $past(rst_n) |-> phase != $past(phase));
  a_r1_slow_align: assert property (@(posedge clk_slow) disable iff (!rst_n)
    $past(rst_n) |-> !phase);
  // R7: a flagged byte never carries the K28 six-bit pattern
  a_r7_flag_is_data: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ctl_invalid |-> (code_out[5:0] != 6'b111100 && code_out[5:0] != 6'b000011));

endmodule

// File: tb/tb_byte_pair_8b10b_tx.sv
module tb_byte_pair_8b10b_tx;
  logic clk_fast = 1'b0, clk_slow = 1'b0, ph = 1'b0, rst_n = 1'b0;
  logic [15:0] tx_word = '0;
  logic [1:0]  tx_k = '0, disp_force = '0, disp_pos = '0;
  logic [9:0]  code_out;
  logic        ctl_invalid;
  int checks = 0, failures = 0, rd_b = -1;
  bit done = 0;

  byte_pair_8b10b_tx dut (.clk_fast(clk_fast), .clk_slow(clk_slow), .rst_n(rst_n),
    .tx_word(tx_word), .tx_k(tx_k), .disp_force(disp_force), .disp_pos(disp_pos),
    .code_out(code_out), .ctl_invalid(ctl_invalid));

  always begin
    #10 clk_fast = 1'b1; clk_slow = !ph; ph = !ph;
    #10 clk_fast = 1'b0;
  end

  // word, k, force, pos, lo group (a..j), hi group (a..j), lo flag, hi flag
  localparam int NV = 14;
  localparam logic [43:0] VEC [NV] = '{
    {16'hBCBC, 2'b01, 2'b00, 2'b00, 10'b0011111010, 10'b0011101010, 1'b0, 1'b0},
    {16'h7883, 2'b00, 2'b00, 2'b00, 10'b1100010010, 10'b1100110011, 1'b0, 1'b0},
    {16'h000F, 2'b00, 2'b00, 2'b00, 10'b1010001011, 10'b0110001011, 1'b0, 1'b0},
    {16'h3CBF, 2'b00, 2'b00, 2'b00, 10'b0101001010, 10'b0011101001, 1'b0, 1'b0},
    {16'hEBF1, 2'b00, 2'b00, 2'b00, 10'b1000110111, 10'b1101001000, 1'b0, 1'b0},
    {16'hFC83, 2'b11, 2'b00, 2'b00, 10'b1100011101, 10'b1100000111, 1'b1, 1'b0},
    {16'h83BC, 2'b01, 2'b01, 2'b00, 10'b0011111010, 10'b1100010010, 1'b0, 1'b0},
    {16'hF7BC, 2'b11, 2'b01, 2'b01, 10'b1100000101, 10'b1110101000, 1'b0, 1'b0},
    {16'hFF1C, 2'b11, 2'b00, 2'b00, 10'b0011110100, 10'b1010110001, 1'b0, 1'b1},
    {16'h3C78, 2'b10, 2'b00, 2'b00, 10'b1100110011, 10'b1100000110, 1'b0, 1'b0},
    {16'h6707, 2'b00, 2'b00, 2'b00, 10'b1110001011, 10'b0001110011, 1'b0, 1'b0},
    {16'hFEEE, 2'b10, 2'b00, 2'b00, 10'b0111001000, 10'b0111101000, 1'b0, 1'b0},
    {16'h00F1, 2'b01, 2'b01, 2'b01, 10'b1000110001, 10'b1001110100, 1'b1, 1'b0},
    {16'h0083, 2'b00, 2'b00, 2'b00, 10'b1100011101, 10'b0110001011, 1'b0, 1'b0}
  };

  function automatic string tag(input int i);
    case (i)
      0: tag = "R3 R1"; 4, 11: tag = "R5"; 5, 8: tag = "R7 R2";
      6, 7: tag = "R6"; 9, 10: tag = "R9"; 12: tag = "R6 R7";
      default: tag = "R2 R1";
    endcase
  endfunction

  function automatic logic [9:0] bus(input logic [9:0] l);
    for (int i = 0; i < 10; i++) bus[i] = l[9-i];
  endfunction

  task automatic chk(input string t, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", t, act, exp);
    end
  endtask

  task automatic track(input logic [9:0] c, input logic f, input logic p);
    int d, nx;
    if (f) rd_b = p ? 1 : -1;
    d  = 2 * $countones(c) - 10;
    nx = rd_b + d;
    checks++;
    if (!(d == 0 || d == 2 || d == -2) || !(nx == 1 || nx == -1)) begin
      failures++;
      $display("FAIL R4 actual disparity=%0d rd=%0d expected |d|<=2 rd=+-1", d, nx);
    end
    rd_b = (nx > 0) ? 1 : -1;
  endtask

  task automatic apply(input int i);
    tx_word = VEC[i][43:28]; tx_k = VEC[i][27:26];
    disp_force = VEC[i][25:24]; disp_pos = VEC[i][23:22];
  endtask

  initial begin
    apply(0);
    #15;
    chk("R8 reset code", code_out, 10'd0);
    chk("R8 reset flag", {9'd0, ctl_invalid}, 10'd0);
    @(posedge clk_slow); #25 rst_n = 1'b1;
    @(posedge clk_slow); #5;
    chk("R8 cleared word gives D0.0", code_out, bus(10'b1001110100));
    track(code_out, 1'b0, 1'b0);
    for (int i = 0; i < NV; i++) begin
      #20;
      chk({tag(i), " low byte"}, code_out, bus(VEC[i][21:12]));
      chk("R7 low flag", {9'd0, ctl_invalid}, {9'd0, VEC[i][1]});
      track(code_out, VEC[i][24], VEC[i][22]);
      if (i + 1 < NV) apply(i + 1);
      #20;
      chk({tag(i), " high byte"}, code_out, bus(VEC[i][11:2]));
      chk("R7 high flag", {9'd0, ctl_invalid}, {9'd0, VEC[i][0]});
      track(code_out, VEC[i][25], VEC[i][23]);
    end
    // disparity is positive here; reset must bring it back to negative
    rst_n = 1'b0;
    #2;
    chk("R8 async clear code", code_out, 10'd0);
    chk("R8 async clear flag", {9'd0, ctl_invalid}, 10'd0);
    tx_word = 16'h00BC; tx_k = 2'b01; disp_force = 2'b00; disp_pos = 2'b00;
    @(posedge clk_slow); #25 rst_n = 1'b1;
    @(posedge clk_slow); #5;
    chk("R8 D0.0 after reset", code_out, bus(10'b1001110100));
    #20;
    chk("R8 K28.5 from negative after reset", code_out, bus(10'b0011111010));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule